// File: doc/BRIEF.md
# Control-Transfer-Record Access Gate

This block sits beside the decode and CSR stages of a processor that keeps a buffer of recent control transfers. Each cycle it may be shown one attempt to touch that buffer's state. The attempt can be a read or write of one of the record CSRs, an access through an indirect register window, or a raw 32-bit instruction word that may be the buffer-clear instruction.

The block weighs the attempt against the current privilege level, the virtualization bit, the machine and hypervisor state-enable bits for the record feature, and three configuration straps. One clock later it returns exactly one verdict: proceed, illegal-instruction or virtual-instruction. When a buffer-clear instruction is allowed, it also sends a one-cycle clear strobe to the record buffer.

The verdict follows a fixed order of rules. Extension presence comes first, then M-mode, then the machine state-enable gate, then plain user mode. The hypervisor state-enable gate comes next, and the virtual-mode rules are applied last. A request that names no record state always proceeds.

Top module: `ctr_access_gate`

## Requirements
- R1: While reset is held, and in any cycle after a cycle with `req_valid` low, all four outputs are 0.
- R2: The cycle after each request, exactly one of `acc_allow`, `acc_illegal` and `acc_virtual` is 1. When the rules for both faults hold, illegal-instruction wins.
- R3: With `req_kind`=2, only the word 0x10400073 is the clear instruction. `ctr_clear` is 1 only together with `acc_allow` on that word. Any other word gives allow with no strobe.
- R4: When `cfg_ctr_ext`=0, every covered access gives illegal in every privilege mode.
- R5: Privilege encoding is `priv` 0=U, 1=S, 3=M. With the extension present, covered accesses from M-mode always proceed, and so do covered accesses from S-mode with the effective virtualization bit at 0.
- R6: A covered access from U-mode with the effective virtualization bit at 0 gives illegal. A covered access with `priv`=2 (reserved) also gives illegal.
- R7: With `cfg_stateen`=1 and `men_ctr`=0, every covered access below M-mode gives illegal. This includes virtual modes, and it holds whatever `hen_ctr` is.
- R8: `req_kind`=1 is a window access. It is covered only when `req_win_sel` lies in 0x200..0x2FF, and this holds for both windows (`req_win_virt` 0 or 1). Outside that range the access proceeds.
- R9: With `cfg_hyp`=1, `cfg_stateen`=1, `men_ctr`=1 and `hen_ctr`=0, covered accesses from VS-mode and VU-mode give virtual.
- R10: `req_kind`=0 selects a CSR through `req_csr_sel`: 1 control, 2 virtual-supervisor control, 3 depth, 4 status, and any other value is not a record CSR. When the hypervisor gate is open, covered VU-mode accesses give virtual. VS-mode accesses to the depth CSR (3) give virtual, and all other VS-mode covered accesses proceed.
- R11: With `cfg_stateen`=0, `men_ctr` and `hen_ctr` have no effect on the verdict.
- R12: With `cfg_hyp`=0, the `virt` input is ignored, and the access is judged as a non-virtual access from the same `priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access attempt is presented this cycle |
| req_kind | input | 2 | 0 CSR, 1 indirect window, 2 instruction word, 3 unrelated |
| req_csr_sel | input | 3 | Record CSR selector (see R10) |
| req_win_virt | input | 1 | 0 supervisor window, 1 virtual-supervisor window |
| req_win_sel | input | SEL_W | Window select value |
| req_insn | input | 32 | Instruction word for kind 2 |
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Virtualization bit |
| men_ctr | input | 1 | Machine state-enable bit for record state |
| hen_ctr | input | 1 | Hypervisor state-enable bit for record state |
| cfg_stateen | input | 1 | State-enable registers implemented |
| cfg_hyp | input | 1 | Hypervisor extension implemented |
| cfg_ctr_ext | input | 1 | Record extension implemented |
| acc_allow | output | 1 | Attempt proceeds |
| acc_illegal | output | 1 | Raise illegal-instruction |
| acc_virtual | output | 1 | Raise virtual-instruction |
| ctr_clear | output | 1 | One-cycle clear strobe to the record buffer |

## Verification
The bench sweeps every mix of privilege, virtualization bit, both state-enable bits and the three straps. Each mix is crossed with every CSR selector, select values on both edges of the window range for both windows, the clear word, and a near-miss instruction word. The sweep separates the state-enable gate from the privilege rules, and the depth-register special case from the other VS-mode accesses. It also shows that the virtualization bit is ignored without a hypervisor and that both state-enable bits are ignored without state-enable. Idle cycles are mixed in so that stuck or stray verdicts and stray clear strobes show up.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;

   typedef enum logic [1:0] {
      PRV_U   = 2'd0,
      PRV_S   = 2'd1,
      PRV_RSV = 2'd2,
      PRV_M   = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      TGT_CSR  = 2'd0,
      TGT_WIN  = 2'd1,
      TGT_INSN = 2'd2,
      TGT_NONE = 2'd3
   } tgt_e;

   localparam logic [2:0] CSR_CTL   = 3'd1;
   localparam logic [2:0] CSR_VSCTL = 3'd2;
   localparam logic [2:0] CSR_DEPTH = 3'd3;
   localparam logic [2:0] CSR_STAT  = 3'd4;

   localparam logic [31:0] CLEAR_WORD = 32'h1040_0073;

   typedef struct packed {
      logic allow;
      logic illegal;
      logic virt;
      logic clear;
   } verdict_t;

   typedef struct packed {
      logic m;
      logic hs;
      logic u;
      logic vs;
      logic vu;
      logic rsv;
   } mode_t;

endpackage

// File: rtl/ctr_target_decode.sv
module ctr_target_decode
   import ctr_gate_pkg::*;
#(
   parameter int SEL_W  = 12,
   parameter int WIN_LO = 'h200,
   parameter int WIN_HI = 'h2FF
) (
   input  logic [1:0]       kind,
   input  logic [2:0]       csr_sel,
   input  logic [SEL_W-1:0] win_sel,
   input  logic [31:0]      insn,
   output logic             covered,
   output logic             is_depth,
   output logic             is_clear
);
   localparam logic [SEL_W-1:0] LO_V = SEL_W'(WIN_LO);
   localparam logic [SEL_W-1:0] HI_V = SEL_W'(WIN_HI);

   generate
      if (WIN_HI >= (1 << SEL_W) || WIN_LO > WIN_HI) begin : g_bad_range
         $error("ctr_target_decode: window range does not fit SEL_W");
      end
   endgenerate

   tgt_e kind_e;
   logic csr_hit;
   logic win_hit;

   always_comb begin
      kind_e   = tgt_e'(kind);
      csr_hit  = (csr_sel == CSR_CTL) || (csr_sel == CSR_VSCTL) ||
                 (csr_sel == CSR_DEPTH) || (csr_sel == CSR_STAT);
      win_hit  = (win_sel >= LO_V) && (win_sel <= HI_V);
      is_clear = (kind_e == TGT_INSN) && (insn == CLEAR_WORD);
      is_depth = (kind_e == TGT_CSR) && (csr_sel == CSR_DEPTH);
      unique case (kind_e)
         TGT_CSR:  covered = csr_hit;
         TGT_WIN:  covered = win_hit;
         TGT_INSN: covered = is_clear;
         default:  covered = 1'b0;
      endcase
   end
endmodule

// File: rtl/ctr_mode_resolve.sv
module ctr_mode_resolve
   import ctr_gate_pkg::*;
(
   input  logic [1:0] priv,
   input  logic       virt,
   input  logic       cfg_hyp,
   input  logic       cfg_stateen,
   input  logic       men_ctr,
   input  logic       hen_ctr,
   output mode_t      mode,
   output logic       m_gate_closed,
   output logic       h_gate_closed
);
   priv_e p;
   logic  v_eff;
   logic  hen_eff;

   always_comb begin
      p       = priv_e'(priv);
      v_eff   = virt & cfg_hyp;
      // the hypervisor bit reads as zero while the machine bit is clear
      hen_eff = men_ctr & hen_ctr;
      mode    = '0;
      mode.m   = (p == PRV_M);
      mode.rsv = (p == PRV_RSV);
      mode.hs  = (p == PRV_S) & ~v_eff;
      mode.u   = (p == PRV_U) & ~v_eff;
      mode.vs  = (p == PRV_S) &  v_eff;
      mode.vu  = (p == PRV_U) &  v_eff;
      m_gate_closed = cfg_stateen & ~men_ctr;
      h_gate_closed = cfg_stateen & ~hen_eff;
   end
endmodule

// File: rtl/ctr_fault_select.sv
module ctr_fault_select
   import ctr_gate_pkg::*;
(
   input  logic     covered,
   input  logic     is_depth,
   input  logic     is_clear,
   input  logic     ext_present,
   input  mode_t    mode,
   input  logic     m_gate_closed,
   input  logic     h_gate_closed,
   output verdict_t verdict
);
   logic ill;
   logic vir;

   always_comb begin
      ill = 1'b0;
      vir = 1'b0;
      if (covered) begin
         if (!ext_present)                   ill = 1'b1;
         else if (mode.m)                    ill = 1'b0;
         else if (mode.rsv || mode.u)        ill = 1'b1;
         else if (m_gate_closed)             ill = 1'b1;
         else if (mode.vs || mode.vu) begin
            if (h_gate_closed || mode.vu || is_depth) vir = 1'b1;
         end
      end
      verdict.illegal = ill;
      verdict.virt    = vir;
      verdict.allow   = ~ill & ~vir;
      verdict.clear   = is_clear & ~ill & ~vir;
   end
endmodule

// File: rtl/ctr_access_gate.sv
module ctr_access_gate
   import ctr_gate_pkg::*;
#(
   parameter int SEL_W   = 12,
   parameter int WIN_LO  = 'h200,
   parameter int WIN_HI  = 'h2FF,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [2:0]       req_csr_sel,
   input  logic             req_win_virt,
   input  logic [SEL_W-1:0] req_win_sel,
   input  logic [31:0]      req_insn,
   input  logic [1:0]       priv,
   input  logic             virt,
   input  logic             men_ctr,
   input  logic             hen_ctr,
   input  logic             cfg_stateen,
   input  logic             cfg_hyp,
   input  logic             cfg_ctr_ext,
   output logic             acc_allow,
   output logic             acc_illegal,
   output logic             acc_virtual,
   output logic             ctr_clear
);
   logic     covered, is_depth, is_clear;
   logic     m_closed, h_closed;
   mode_t    mode;
   verdict_t vd, vd_gated;

   // both windows share one select range; req_win_virt only routes data
   logic win_virt_unused;
   assign win_virt_unused = req_win_virt;

   ctr_target_decode #(.SEL_W(SEL_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) i_decode (
      .kind(req_kind), .csr_sel(req_csr_sel), .win_sel(req_win_sel),
      .insn(req_insn), .covered(covered), .is_depth(is_depth), .is_clear(is_clear)
   );

   ctr_mode_resolve i_mode (
      .priv(priv), .virt(virt), .cfg_hyp(cfg_hyp), .cfg_stateen(cfg_stateen),
      .men_ctr(men_ctr), .hen_ctr(hen_ctr), .mode(mode),
      .m_gate_closed(m_closed), .h_gate_closed(h_closed)
   );

   ctr_fault_select i_select (
      .covered(covered), .is_depth(is_depth), .is_clear(is_clear),
      .ext_present(cfg_ctr_ext), .mode(mode), .m_gate_closed(m_closed),
      .h_gate_closed(h_closed), .verdict(vd)
   );

   assign vd_gated = req_valid ? vd : '0;

   generate
      if (OUT_REG) begin : g_reg
         verdict_t vd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) vd_q <= '0;
            else        vd_q <= vd_gated;
         end
         assign acc_allow   = vd_q.allow;
         assign acc_illegal = vd_q.illegal;
         assign acc_virtual = vd_q.virt;
         assign ctr_clear   = vd_q.clear;
      end else begin : g_comb
         assign acc_allow   = vd_gated.allow;
         assign acc_illegal = vd_gated.illegal;
         assign acc_virtual = vd_gated.virt;
         assign ctr_clear   = vd_gated.clear;
      end
   endgenerate
endmodule

// File: rtl/ctr_access_gate_chk.sv
module ctr_access_gate_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] priv,
   input logic       virt,
   input logic       cfg_hyp,
   input logic       cfg_ctr_ext,
   input logic       acc_allow,
   input logic       acc_illegal,
   input logic       acc_virtual,
   input logic       ctr_clear
);
   generate
      if (OUT_REG) begin : g_chk
         AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> $countones({acc_allow, acc_illegal, acc_virtual}) == 1); // R2
         AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> !(acc_allow || acc_illegal || acc_virtual || ctr_clear)); // R1
         AST_CLEAR_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ctr_clear |-> acc_allow); // R3
         AST_M_MODE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && priv == 2'd3 && cfg_ctr_ext) |=> acc_allow); // R5
         AST_USER_NOT_VIRTUAL: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && priv == 2'd0 && !virt) |=> !acc_virtual); // R6
         AST_NO_HYP_NO_VIRTUAL: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !cfg_hyp) |=> !acc_virtual); // R12
      end
   endgenerate
endmodule

bind ctr_access_gate ctr_access_gate_chk #(.OUT_REG(OUT_REG)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .priv(priv), .virt(virt),
   .cfg_hyp(cfg_hyp), .cfg_ctr_ext(cfg_ctr_ext), .acc_allow(acc_allow),
   .acc_illegal(acc_illegal), .acc_virtual(acc_virtual), .ctr_clear(ctr_clear)
);

// File: tb/test_ctr_access_gate.sv
module test_ctr_access_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd3;
   logic [2:0]  req_csr_sel = '0;
   logic        req_win_virt = 1'b0;
   logic [11:0] req_win_sel = '0;
   logic [31:0] req_insn = '0;
   logic [1:0]  priv = '0;
   logic        virt = 1'b0, men_ctr = 1'b0, hen_ctr = 1'b0;
   logic        cfg_stateen = 1'b0, cfg_hyp = 1'b0, cfg_ctr_ext = 1'b0;
   logic        acc_allow, acc_illegal, acc_virtual, ctr_clear;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   bit    pend_valid = 1'b0;
   bit    e_a, e_i, e_v, e_c;
   string e_tag;

   always #5 clk = ~clk;

   ctr_access_gate i_ctr_access_gate (.*);

   // behavioural reference: one verdict per request from the requirement list
   task automatic model(input int kind, input int csr, input int sel, input logic [31:0] word,
                        input int pv, input bit vb, input bit me, input bit he,
                        input bit se, input bit hy, input bit ex,
                        output bit a, output bit il, output bit vi, output bit cl,
                        output string tag);
      bit cov, clr_word, vmode;
      clr_word = (kind == 2) && (word == 32'h1040_0073);
      cov = ((kind == 0) && csr >= 1 && csr <= 4) ||
            ((kind == 1) && sel >= 'h200 && sel <= 'h2FF) || clr_word;
      a = 1'b0; il = 1'b0; vi = 1'b0;
      vmode = vb && hy;
      if (!cov) begin
         a = 1'b1; tag = (kind == 2) ? "R3" : (kind == 1) ? "R8" : "R10";
      end else if (!ex) begin
         il = 1'b1; tag = "R4";
      end else if (pv == 3) begin
         a = 1'b1; tag = "R5";
      end else if (pv == 2) begin
         il = 1'b1; tag = "R6";
      end else if (se && !me) begin
         il = 1'b1; tag = "R7";
      end else if (!vmode) begin
         if (pv == 0) il = 1'b1; else a = 1'b1;
         tag = (vb && !hy) ? "R12" : (pv == 0) ? "R6" : "R5";
      end else if (se && !he) begin
         vi = 1'b1; tag = "R9";
      end else if (pv == 0 || (kind == 0 && csr == 3)) begin
         vi = 1'b1; tag = se ? "R10" : "R11";
      end else begin
         a = 1'b1; tag = se ? "R10" : "R11";
      end
      cl = a && clr_word;
      if (cl) tag = "R3";
   endtask

   task automatic compare_now();
      bit xa, xi, xv, xc;
      string t;
      if (pend_valid) begin
         xa = e_a; xi = e_i; xv = e_v; xc = e_c; t = e_tag;
      end else begin
         xa = 0; xi = 0; xv = 0; xc = 0; t = "R1";
      end
      n_cmp++;
      if ({acc_allow, acc_illegal, acc_virtual, ctr_clear} != {xa, xi, xv, xc}) begin
         n_bad++;
         $display("FAIL %s: got a/i/v/c=%b%b%b%b expected %b%b%b%b", t,
                  acc_allow, acc_illegal, acc_virtual, ctr_clear, xa, xi, xv, xc);
      end
      if (pend_valid) begin
         n_cmp++;
         if ((acc_allow + acc_illegal + acc_virtual) != 1) begin
            n_bad++;
            $display("FAIL R2: verdict count %0d expected 1",
                     acc_allow + acc_illegal + acc_virtual);
         end
      end
   endtask

   task automatic step(input bit vld, input int kind, input int csr, input int sel,
                       input bit wv, input logic [31:0] word, input int pv, input bit vb,
                       input bit me, input bit he, input bit se, input bit hy, input bit ex);
      @(negedge clk);
      compare_now();
      req_valid = vld; req_kind = 2'(kind); req_csr_sel = 3'(csr);
      req_win_sel = 12'(sel); req_win_virt = wv; req_insn = word;
      priv = 2'(pv); virt = vb; men_ctr = me; hen_ctr = he;
      cfg_stateen = se; cfg_hyp = hy; cfg_ctr_ext = ex;
      pend_valid = vld;
      if (vld) model(kind, csr, sel, word, pv, vb, me, he, se, hy, ex, e_a, e_i, e_v, e_c, e_tag);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare_now();          // R1 reset state
      rst_n = 1'b1;
      for (int cfg = 0; cfg < 128; cfg++) begin
         for (int t = 0; t < 16; t++) begin
            int kind, csr, sel; bit wv; logic [31:0] w;
            kind = 0; csr = 0; sel = 0; wv = 0; w = 32'h0000_0013;
            if (t < 6) begin kind = 0; csr = t; end
            else if (t < 12) begin
               kind = 1; wv = t[0];
               sel = (t < 8) ? 'h1FF : (t < 10) ? 'h200 + (t - 8) * 'hFF : 'h300;
            end
            else if (t == 12) begin kind = 2; w = 32'h1040_0073; end
            else if (t == 13) begin kind = 2; w = 32'h1040_00F3; end
            else if (t == 14) kind = 3;
            step(t != 15, kind, csr, sel, wv, w, cfg[1:0], cfg[2], cfg[3], cfg[4],
                 cfg[5], cfg[6], 1'b1 ^ (cfg[1:0] == 2'd1 && cfg[6:2] == 5'd0));
         end
         // extension absent pass for R4
         step(1'b1, 0, 3, 0, 1'b0, 32'h0, cfg[1:0], cfg[2], cfg[3], cfg[4], cfg[5], cfg[6], 1'b0);
         step(1'b1, 2, 0, 0, 1'b0, 32'h1040_0073, cfg[1:0], cfg[2], cfg[3], cfg[4], cfg[5], cfg[6], 1'b0);
      end
      step(1'b0, 3, 0, 0, 1'b0, 32'h0, 0, 0, 0, 0, 0, 0, 0);
      step(1'b0, 3, 0, 0, 1'b0, 32'h0, 0, 0, 0, 0, 0, 0, 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule